// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the host-facing register file of a four-channel DMA controller. A processor reaches it through an 8-bit I/O port with a 4-bit offset. For each channel it holds a 16-bit start address, running address, start count and running count. The host moves these one byte at a time. A single byte-order pointer, shared by every 16-bit port, decides which byte each access moves. The bank also holds the command, mode, mask, request, terminal-count and scratch registers. It decodes the write-only strobe offsets, which have side effects.

The transfer engine sits outside this block. It reads the register buses directly. Through an update port it writes back running address and count values after each burst. The same port flags the end of a channel's transfer: that sets its terminal-count bit, drops its pending request, and then either reloads the running registers from the start registers or masks the channel. A second engine strobe loads the scratch register.

Top module: `dma_reg_bank`

## Requirements
- R1: After hardware reset every address, count and mode register is 0, command, terminal-count, request and scratch are 0, the byte pointer is 0 and the mask output is 4'hF.
- R2: A write to offset 2c (c = 0..3) updates the start and running address of channel c, and a write to offset 2c+1 updates its start and running count. Both start and running registers take the low byte when the byte pointer is 0 and the high byte when it is 1. Each such access toggles the pointer.
- R3: A read of offsets 0..7 returns the running address (even offset) or running count (odd offset) of channel offset[2:1]. It returns the low byte when the pointer is 0 and the high byte when it is 1, and then toggles the pointer.
- R4: A write to offset 0xC clears the byte pointer. A write to offset 0xD is a master reset: command, terminal-count, request, scratch and pointer go to 0 and the mask goes to 4'hF. Addresses, counts and modes are left unchanged.
- R5: A write to offset 0xB stores data with bits 1:0 forced to 0 as the mode of the channel named by data[1:0].
- R6: A write to offset 0xA sets the mask bit of channel data[1:0] when data[2] is 1 and clears it when data[2] is 0.
- R7: A write to offset 0xF loads the mask from data[3:0], and a read of 0xF returns {4'b0, mask}. A write to offset 0xE clears all mask bits.
- R8: A write to offset 0x8 loads the command register. A read of 0x8 returns status, with the request bits in 7:4 and the terminal-count bits in 3:0.
- R9: A write to offset 0x9 sets the request bit of channel data[1:0] when data[2] is 1 and clears it otherwise.
- R10: A read of 0xD returns the scratch register, which the engine loads with engTempEn. Reads of 0x9, 0xA, 0xB, 0xC and 0xE return 0x00 and leave the pointer unchanged. ioRdData is 0 when no read is active.
- R11: An engine update loads the running address and count of engChan. With engDone it also sets that channel's terminal-count bit and clears its request bit. It then either reloads both running registers from the start registers (engReload=1) or sets the channel's mask bit (engReload=0).
- R12: When events coincide, precedence is as follows. A master reset overrides the engine's effect on status, request, mask and scratch. A host write to a channel's address or count port overrides the engine's update of that same register. The engine's mask set and request clear win over a host mask or request write in the same cycle.
- R13: In a cycle with no host access and no engine strobe, no register output and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWrEn | input | 1 | Host write strobe |
| ioRdEn | input | 1 | Host read strobe |
| ioOffset | input | 4 | Port offset |
| ioWrData | input | 8 | Host write data |
| ioRdData | output | 8 | Host read data (combinational) |
| engUpdEn | input | 1 | Engine write-back of running registers |
| engChan | input | 2 | Channel of the engine update |
| engAddr | input | 16 | New running address |
| engCount | input | 16 | New running count |
| engDone | input | 1 | Terminal count reached on engChan |
| engReload | input | 1 | On done: 1 reloads from start values, 0 masks the channel |
| engTempEn | input | 1 | Load the scratch register |
| engTempData | input | 8 | Scratch value |
| baseAddrBus | output | 64 | Start addresses, channel c at bits 16c+15:16c |
| curAddrBus | output | 64 | Running addresses |
| baseCntBus | output | 64 | Start counts |
| curCntBus | output | 64 | Running counts |
| modeBus | output | 32 | Channel modes, channel c at bits 8c+7:8c |
| maskOut | output | 4 | Channel mask bits |
| cmdOut | output | 8 | Command register |
| statusOut | output | 8 | {request, terminal count} |
| bytePtr | output | 1 | Byte-order pointer |

## Verification
The host port and the engine update port act in the same cycle. The interesting cases are those where both touch the same state. The bench provokes these cases deliberately:
- a master reset together with an engine completion;
- a host byte write to a channel's address port while the engine writes back that channel;
- a clear-all-mask strobe while the engine masks a finished channel;
- a request-set write while the engine retires the same channel's request.

A behavioural model applies the precedence rules of R12 in every cycle, and each output bus is judged against it at the following falling edge.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int DATA_W = 8;
  localparam int WORD_W = 2 * DATA_W;
  localparam int OFS_W  = 4;

  localparam logic [OFS_W-1:0] OFS_STATCMD = 4'h8;
  localparam logic [OFS_W-1:0] OFS_REQ     = 4'h9;
  localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [OFS_W-1:0] OFS_PTRCLR  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MRST    = 4'hD;
  localparam logic [OFS_W-1:0] OFS_MASKCLR = 4'hE;
  localparam logic [OFS_W-1:0] OFS_MASKALL = 4'hF;

  typedef struct packed {
    logic            addrWr;
    logic            cntWr;
    logic [CH_W-1:0] chSel;
    logic            hiByte;
    logic            cmdWr;
    logic            reqWr;
    logic            maskOneWr;
    logic            modeWr;
    logic            maskAllWr;
    logic            maskClr;
    logic            masterRst;
  } regStrobe_t;

  function automatic logic [WORD_W-1:0] mergeByte(input logic [WORD_W-1:0] word,
                                                  input logic [DATA_W-1:0] b,
                                                  input logic hi);
    logic [WORD_W-1:0] r;
    r = word;
    if (hi) r[WORD_W-1:DATA_W] = b;
    else    r[DATA_W-1:0]      = b;
    return r;
  endfunction
endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioWrEn,
  input  logic             ioRdEn,
  input  logic [OFS_W-1:0] ioOffset,
  output regStrobe_t       stb,
  output logic             bytePtr
);
  logic ptrQ;
  logic wordPort;
  logic ptrClr;

  // offsets 0..7 are the 16-bit channel ports
  assign wordPort = ~ioOffset[OFS_W-1];
  assign ptrClr   = ioWrEn && (ioOffset == OFS_PTRCLR);

  always_comb begin
    stb           = '0;
    stb.addrWr    = ioWrEn && wordPort && !ioOffset[0];
    stb.cntWr     = ioWrEn && wordPort &&  ioOffset[0];
    stb.chSel     = ioOffset[CH_W:1];
    stb.hiByte    = ptrQ;
    stb.cmdWr     = ioWrEn && (ioOffset == OFS_STATCMD);
    stb.reqWr     = ioWrEn && (ioOffset == OFS_REQ);
    stb.maskOneWr = ioWrEn && (ioOffset == OFS_MASK1);
    stb.modeWr    = ioWrEn && (ioOffset == OFS_MODE);
    stb.maskAllWr = ioWrEn && (ioOffset == OFS_MASKALL);
    stb.maskClr   = ioWrEn && (ioOffset == OFS_MASKCLR);
    stb.masterRst = ioWrEn && (ioOffset == OFS_MRST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              ptrQ <= 1'b0;
    else if (stb.masterRst || ptrClr)       ptrQ <= 1'b0;
    else if ((ioWrEn || ioRdEn) && wordPort) ptrQ <= ~ptrQ;
  end

  assign bytePtr = ptrQ;
endmodule

// File: rtl/dma_reg_data.sv
module dma_reg_data
  import dma_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               stb,
  input  logic [OFS_W-1:0]         ioOffset,
  input  logic                     ioRdEn,
  input  logic [DATA_W-1:0]        ioWrData,
  input  logic                     engUpdEn,
  input  logic [CH_W-1:0]          engChan,
  input  logic [WORD_W-1:0]        engAddr,
  input  logic [WORD_W-1:0]        engCount,
  input  logic                     engDone,
  input  logic                     engReload,
  input  logic                     engTempEn,
  input  logic [DATA_W-1:0]        engTempData,
  output logic [DATA_W-1:0]        ioRdData,
  output logic [NUM_CH*WORD_W-1:0] baseAddrBus,
  output logic [NUM_CH*WORD_W-1:0] curAddrBus,
  output logic [NUM_CH*WORD_W-1:0] baseCntBus,
  output logic [NUM_CH*WORD_W-1:0] curCntBus,
  output logic [NUM_CH*DATA_W-1:0] modeBus,
  output logic [NUM_CH-1:0]        maskOut,
  output logic [DATA_W-1:0]        cmdOut,
  output logic [DATA_W-1:0]        statusOut
);
  localparam logic [NUM_CH-1:0] MASK_ALL = '1;

  logic              engFinish;
  logic [NUM_CH-1:0] engChanDec;
  logic [NUM_CH-1:0] hostChanDec;
  logic [NUM_CH-1:0] maskQ, maskD;
  logic [NUM_CH-1:0] tcQ, tcD;
  logic [NUM_CH-1:0] reqQ, reqD;
  logic [DATA_W-1:0] cmdQ, tempQ;

  assign engFinish   = engUpdEn && engDone;
  assign engChanDec  = NUM_CH'(1) << engChan;
  assign hostChanDec = NUM_CH'(1) << ioWrData[CH_W-1:0];

  // per-channel word registers
  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic [WORD_W-1:0] baseAddrQ, curAddrQ, baseCntQ, curCntQ;
    logic [DATA_W-1:0] modeQ;
    logic hostAddrHit, hostCntHit, engHit, reloadHit, modeHit;

    assign hostAddrHit = stb.addrWr && (stb.chSel == CH_W'(i));
    assign hostCntHit  = stb.cntWr  && (stb.chSel == CH_W'(i));
    assign engHit      = engUpdEn && (engChan == CH_W'(i));
    assign reloadHit   = engHit && engDone && engReload;
    assign modeHit     = stb.modeWr && (ioWrData[CH_W-1:0] == CH_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseAddrQ <= '0;
        curAddrQ  <= '0;
        baseCntQ  <= '0;
        curCntQ   <= '0;
        modeQ     <= '0;
      end else begin
        if (hostAddrHit) begin
          baseAddrQ <= mergeByte(baseAddrQ, ioWrData, stb.hiByte);
          curAddrQ  <= mergeByte(curAddrQ,  ioWrData, stb.hiByte);
        end else if (reloadHit) begin
          curAddrQ <= baseAddrQ;
        end else if (engHit) begin
          curAddrQ <= engAddr;
        end

        if (hostCntHit) begin
          baseCntQ <= mergeByte(baseCntQ, ioWrData, stb.hiByte);
          curCntQ  <= mergeByte(curCntQ,  ioWrData, stb.hiByte);
        end else if (reloadHit) begin
          curCntQ <= baseCntQ;
        end else if (engHit) begin
          curCntQ <= engCount;
        end

        if (modeHit) modeQ <= {ioWrData[DATA_W-1:CH_W], CH_W'(0)};
      end
    end

    assign baseAddrBus[i*WORD_W +: WORD_W] = baseAddrQ;
    assign curAddrBus[i*WORD_W +: WORD_W]  = curAddrQ;
    assign baseCntBus[i*WORD_W +: WORD_W]  = baseCntQ;
    assign curCntBus[i*WORD_W +: WORD_W]   = curCntQ;
    assign modeBus[i*DATA_W +: DATA_W]     = modeQ;
  end

  // shared control registers: host first, engine next, master reset last
  always_comb begin
    maskD = maskQ;
    if (stb.maskAllWr) maskD = ioWrData[NUM_CH-1:0];
    if (stb.maskClr)   maskD = '0;
    if (stb.maskOneWr) begin
      if (ioWrData[CH_W]) maskD = maskD | hostChanDec;
      else                maskD = maskD & ~hostChanDec;
    end
    if (engFinish && !engReload) maskD = maskD | engChanDec;
    if (stb.masterRst) maskD = MASK_ALL;
  end

  always_comb begin
    reqD = reqQ;
    tcD  = tcQ;
    if (stb.reqWr) begin
      if (ioWrData[CH_W]) reqD = reqD | hostChanDec;
      else                reqD = reqD & ~hostChanDec;
    end
    if (engFinish) begin
      reqD = reqD & ~engChanDec;
      tcD  = tcD | engChanDec;
    end
    if (stb.masterRst) begin
      reqD = '0;
      tcD  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= MASK_ALL;
      reqQ  <= '0;
      tcQ   <= '0;
      cmdQ  <= '0;
      tempQ <= '0;
    end else begin
      maskQ <= maskD;
      reqQ  <= reqD;
      tcQ   <= tcD;
      if (stb.masterRst)  cmdQ <= '0;
      else if (stb.cmdWr) cmdQ <= ioWrData;
      if (stb.masterRst)  tempQ <= '0;
      else if (engTempEn) tempQ <= engTempData;
    end
  end

  // read mux
  logic [WORD_W-1:0] rdWord;
  always_comb begin
    rdWord   = ioOffset[0] ? curCntBus[ioOffset[CH_W:1]*WORD_W +: WORD_W]
                           : curAddrBus[ioOffset[CH_W:1]*WORD_W +: WORD_W];
    ioRdData = '0;
    if (ioRdEn) begin
      if (!ioOffset[OFS_W-1]) begin
        ioRdData = stb.hiByte ? rdWord[WORD_W-1:DATA_W] : rdWord[DATA_W-1:0];
      end else begin
        case (ioOffset)
          OFS_STATCMD: ioRdData = {reqQ, tcQ};
          OFS_MRST:    ioRdData = tempQ;
          OFS_MASKALL: ioRdData = DATA_W'(maskQ);
          default:     ioRdData = '0;
        endcase
      end
    end
  end

  assign maskOut   = maskQ;
  assign cmdOut    = cmdQ;
  assign statusOut = {reqQ, tcQ};
endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
  import dma_reg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ioWrEn,
  input  logic                     ioRdEn,
  input  logic [OFS_W-1:0]         ioOffset,
  input  logic [DATA_W-1:0]        ioWrData,
  output logic [DATA_W-1:0]        ioRdData,
  input  logic                     engUpdEn,
  input  logic [CH_W-1:0]          engChan,
  input  logic [WORD_W-1:0]        engAddr,
  input  logic [WORD_W-1:0]        engCount,
  input  logic                     engDone,
  input  logic                     engReload,
  input  logic                     engTempEn,
  input  logic [DATA_W-1:0]        engTempData,
  output logic [NUM_CH*WORD_W-1:0] baseAddrBus,
  output logic [NUM_CH*WORD_W-1:0] curAddrBus,
  output logic [NUM_CH*WORD_W-1:0] baseCntBus,
  output logic [NUM_CH*WORD_W-1:0] curCntBus,
  output logic [NUM_CH*DATA_W-1:0] modeBus,
  output logic [NUM_CH-1:0]        maskOut,
  output logic [DATA_W-1:0]        cmdOut,
  output logic [DATA_W-1:0]        statusOut,
  output logic                     bytePtr
);
  regStrobe_t stb;

  dma_reg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioWrEn   (ioWrEn),
    .ioRdEn   (ioRdEn),
    .ioOffset (ioOffset),
    .stb      (stb),
    .bytePtr  (bytePtr)
  );

  dma_reg_data u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ioOffset    (ioOffset),
    .ioRdEn      (ioRdEn),
    .ioWrData    (ioWrData),
    .engUpdEn    (engUpdEn),
    .engChan     (engChan),
    .engAddr     (engAddr),
    .engCount    (engCount),
    .engDone     (engDone),
    .engReload   (engReload),
    .engTempEn   (engTempEn),
    .engTempData (engTempData),
    .ioRdData    (ioRdData),
    .baseAddrBus (baseAddrBus),
    .curAddrBus  (curAddrBus),
    .baseCntBus  (baseCntBus),
    .curCntBus   (curCntBus),
    .modeBus     (modeBus),
    .maskOut     (maskOut),
    .cmdOut      (cmdOut),
    .statusOut   (statusOut)
  );
endmodule

// File: rtl/dma_reg_bank_chk.sv
module dma_reg_bank_chk
  import dma_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ioWrEn,
  input logic              ioRdEn,
  input logic [OFS_W-1:0]  ioOffset,
  input logic [DATA_W-1:0] ioRdData,
  input logic              engUpdEn,
  input logic [CH_W-1:0]   engChan,
  input logic              engDone,
  input logic              engReload,
  input logic              engTempEn,
  input logic [NUM_CH-1:0] maskOut,
  input logic [DATA_W-1:0] cmdOut,
  input logic [DATA_W-1:0] statusOut,
  input logic              bytePtr
);
  logic mrstWr, wordAcc, writeOnlyRd, engMaskSet, idle;
  assign mrstWr      = ioWrEn && (ioOffset == OFS_MRST);
  assign wordAcc     = (ioWrEn || ioRdEn) && !ioOffset[OFS_W-1];
  assign writeOnlyRd = ioRdEn && !ioWrEn &&
                       (ioOffset == OFS_REQ || ioOffset == OFS_MASK1 || ioOffset == OFS_MODE ||
                        ioOffset == OFS_PTRCLR || ioOffset == OFS_MASKCLR);
  assign engMaskSet  = engUpdEn && engDone && !engReload;
  assign idle        = !ioWrEn && !ioRdEn && !engUpdEn && !engTempEn;

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    wordAcc |=> bytePtr != $past(bytePtr)); // R2

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioOffset == OFS_PTRCLR) |=> !bytePtr); // R4

  AST_MRST_STATE: assert property (@(posedge clk) disable iff (!rstN)
    mrstWr |=> (maskOut == '1) && (cmdOut == '0) && (statusOut == '0) && !bytePtr); // R4

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioOffset == OFS_MASKCLR && !engMaskSet) |=> maskOut == '0); // R7

  AST_WONLY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    writeOnlyRd |-> ioRdData == '0); // R10

  AST_TC_SET: assert property (@(posedge clk) disable iff (!rstN)
    (engUpdEn && engDone && !mrstWr) |=> statusOut[$past(engChan)]); // R11

  AST_ENG_MASK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    engMaskSet |=> maskOut[$past(engChan)]); // R12

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> $stable(maskOut) && $stable(cmdOut) && $stable(statusOut) && $stable(bytePtr)); // R13
endmodule

bind dma_reg_bank dma_reg_bank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ioWrEn    (ioWrEn),
  .ioRdEn    (ioRdEn),
  .ioOffset  (ioOffset),
  .ioRdData  (ioRdData),
  .engUpdEn  (engUpdEn),
  .engChan   (engChan),
  .engDone   (engDone),
  .engReload (engReload),
  .engTempEn (engTempEn),
  .maskOut   (maskOut),
  .cmdOut    (cmdOut),
  .statusOut (statusOut),
  .bytePtr   (bytePtr)
);

// File: tb/sim_dma_reg_bank.sv
`timescale 1ns/1ps
module sim_dma_reg_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        ioWrEn = 0, ioRdEn = 0;
  logic [3:0]  ioOffset = 0;
  logic [7:0]  ioWrData = 0;
  logic [7:0]  ioRdData;
  logic        engUpdEn = 0, engDone = 0, engReload = 0, engTempEn = 0;
  logic [1:0]  engChan = 0;
  logic [15:0] engAddr = 0, engCount = 0;
  logic [7:0]  engTempData = 0;
  logic [63:0] baseAddrBus, curAddrBus, baseCntBus, curCntBus;
  logic [31:0] modeBus;
  logic [3:0]  maskOut;
  logic [7:0]  cmdOut, statusOut;
  logic        bytePtr;

  dma_reg_bank u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  logic [15:0] mBaseA [4], mCurA [4], mBaseC [4], mCurC [4];
  logic [7:0]  mMode [4];
  logic [3:0]  mMask, mTc, mReq;
  logic [7:0]  mCmd, mTemp;
  logic        mPtr;

  task automatic modelReset();
    for (int c = 0; c < 4; c++) begin
      mBaseA[c] = 0; mCurA[c] = 0; mBaseC[c] = 0; mCurC[c] = 0; mMode[c] = 0;
    end
    mMask = 4'hF; mTc = 0; mReq = 0; mCmd = 0; mTemp = 0; mPtr = 0;
  endtask

  function automatic logic [15:0] putByte(logic [15:0] w, logic [7:0] b, logic hi);
    if (hi) return {b, w[7:0]};
    return {w[15:8], b};
  endfunction

  function automatic logic [7:0] modelRead(logic [3:0] off);
    logic [15:0] w;
    if (off < 8) begin
      w = off[0] ? mCurC[off[2:1]] : mCurA[off[2:1]];
      return mPtr ? w[15:8] : w[7:0];
    end
    case (off)
      4'h8: return {mReq, mTc};
      4'hD: return mTemp;
      4'hF: return {4'h0, mMask};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelStep();
    logic [15:0] oBaseA [4], oBaseC [4];
    int hostA, hostC;
    logic mrst, hi;
    logic [3:0] bit1;
    hi = mPtr;
    mrst = ioWrEn && ioOffset == 4'hD;
    hostA = (ioWrEn && ioOffset < 8 && !ioOffset[0]) ? int'(ioOffset[2:1]) : -1;
    hostC = (ioWrEn && ioOffset < 8 &&  ioOffset[0]) ? int'(ioOffset[2:1]) : -1;
    for (int c = 0; c < 4; c++) begin oBaseA[c] = mBaseA[c]; oBaseC[c] = mBaseC[c]; end
    for (int c = 0; c < 4; c++) begin
      if (c == hostA) begin
        mBaseA[c] = putByte(mBaseA[c], ioWrData, hi);
        mCurA[c]  = putByte(mCurA[c], ioWrData, hi);
      end else if (engUpdEn && int'(engChan) == c) begin
        mCurA[c] = (engDone && engReload) ? oBaseA[c] : engAddr;
      end
      if (c == hostC) begin
        mBaseC[c] = putByte(mBaseC[c], ioWrData, hi);
        mCurC[c]  = putByte(mCurC[c], ioWrData, hi);
      end else if (engUpdEn && int'(engChan) == c) begin
        mCurC[c] = (engDone && engReload) ? oBaseC[c] : engCount;
      end
    end
    bit1 = 4'(1) << ioWrData[1:0];
    if (ioWrEn) begin
      case (ioOffset)
        4'h8: mCmd = ioWrData;
        4'h9: mReq = ioWrData[2] ? (mReq | bit1) : (mReq & ~bit1);
        4'hA: mMask = ioWrData[2] ? (mMask | bit1) : (mMask & ~bit1);
        4'hB: mMode[ioWrData[1:0]] = ioWrData & 8'hFC;
        4'hE: mMask = 0;
        4'hF: mMask = ioWrData[3:0];
        default: ;
      endcase
    end
    if (engUpdEn && engDone) begin
      mReq = mReq & ~(4'(1) << engChan);
      mTc  = mTc | (4'(1) << engChan);
      if (!engReload) mMask = mMask | (4'(1) << engChan);
    end
    if (engTempEn) mTemp = engTempData;
    if (mrst) begin
      mCmd = 0; mTc = 0; mReq = 0; mTemp = 0; mMask = 4'hF;
    end
    if (mrst || (ioWrEn && ioOffset == 4'hC)) mPtr = 0;
    else if ((ioWrEn || ioRdEn) && ioOffset < 8) mPtr = ~mPtr;
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [63:0] eBA, eCA, eBC, eCC;
    logic [31:0] eM;
    for (int c = 0; c < 4; c++) begin
      eBA[c*16 +: 16] = mBaseA[c]; eCA[c*16 +: 16] = mCurA[c];
      eBC[c*16 +: 16] = mBaseC[c]; eCC[c*16 +: 16] = mCurC[c];
      eM[c*8 +: 8] = mMode[c];
    end
    chk("baseAddr", baseAddrBus, eBA);
    chk("curAddr", curAddrBus, eCA);
    chk("baseCnt", baseCntBus, eBC);
    chk("curCnt", curCntBus, eCC);
    chk("mode", 64'(modeBus), 64'(eM));
    chk("mask", 64'(maskOut), 64'(mMask));
    chk("cmd", 64'(cmdOut), 64'(mCmd));
    chk("status", 64'(statusOut), 64'({mReq, mTc}));
    chk("ptr", 64'(bytePtr), 64'(mPtr));
  endtask

  // one clock: inputs are already set (at a falling edge)
  task automatic cyc();
    #1;
    if (ioRdEn) chk("rdData", 64'(ioRdData), 64'(modelRead(ioOffset)));
    else chk("rdIdle", 64'(ioRdData), 64'h0); // R10
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    ioWrEn = 0; ioRdEn = 0; engUpdEn = 0; engDone = 0; engReload = 0; engTempEn = 0;
  endtask

  task automatic hw(logic [3:0] off, logic [7:0] d);
    ioWrEn = 1; ioOffset = off; ioWrData = d; cyc();
  endtask
  task automatic hr(logic [3:0] off);
    ioRdEn = 1; ioOffset = off; cyc();
  endtask
  task automatic eng(logic [1:0] ch, logic [15:0] a, logic [15:0] n, logic done, logic rl);
    engUpdEn = 1; engChan = ch; engAddr = a; engCount = n; engDone = done; engReload = rl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1"; compareAll();

    curReq = "R2"; // address and count byte sequencing
    hw(4'h2, 8'h34); hw(4'h2, 8'h12); hw(4'h3, 8'hFF); hw(4'h3, 8'h00);
    hw(4'h0, 8'hAA); hw(4'h0, 8'h55); hw(4'h7, 8'h10); hw(4'h7, 8'h20);
    hw(4'h6, 8'h01); // leaves pointer high
    curReq = "R4"; hw(4'hC, 8'h00); hw(4'h6, 8'h9C); hw(4'h6, 8'h7E);

    curReq = "R3"; // reads of running registers
    hr(4'h2); hr(4'h2); hr(4'h3); hr(4'h3); hr(4'h7); hr(4'h0);
    hw(4'hC, 8'h00); hr(4'h6); hr(4'h6);

    curReq = "R5";
    hw(4'hB, 8'h57); hw(4'hB, 8'hC4); hw(4'hB, 8'h9A); hw(4'hB, 8'h2F); hw(4'hB, 8'hFD);

    curReq = "R7"; hw(4'hE, 8'h00); hr(4'hF); hw(4'hF, 8'hA5); hr(4'hF);
    curReq = "R6"; hw(4'hA, 8'h04); hw(4'hA, 8'h01); hw(4'hA, 8'h07); hw(4'hA, 8'h03); hr(4'hF);
    curReq = "R8"; hw(4'h8, 8'h3C); hr(4'h8);
    curReq = "R9"; hw(4'h9, 8'h05); hw(4'h9, 8'h07); hr(4'h8); hw(4'h9, 8'h01); hr(4'h8);

    curReq = "R10";
    engTempEn = 1; engTempData = 8'h6B; cyc();
    hr(4'hD); hr(4'h9); hr(4'hA); hr(4'hB); hr(4'hC); hr(4'hE);

    curReq = "R11";
    eng(2'd1, 16'h1240, 16'h00F0, 0, 0); cyc();
    hr(4'h2); hr(4'h2);
    hw(4'h9, 8'h05); eng(2'd1, 16'h1300, 16'h0000, 1, 1); cyc();
    hw(4'hE, 8'h00); eng(2'd3, 16'h7F00, 16'h0000, 1, 0); ioWrEn = 0; cyc();
    hr(4'h8);

    curReq = "R12";
    hw(4'h8, 8'h11);
    eng(2'd2, 16'hBEEF, 16'h0003, 1, 0); engTempEn = 1; engTempData = 8'h99;
    ioWrEn = 1; ioOffset = 4'hD; ioWrData = 0; cyc();
    hw(4'hE, 8'h00);
    eng(2'd0, 16'hDEAD, 16'h4444, 0, 0); ioWrEn = 1; ioOffset = 4'h0; ioWrData = 8'h77; cyc();
    eng(2'd0, 16'h0101, 16'h0202, 1, 1); ioWrEn = 1; ioOffset = 4'h1; ioWrData = 8'h88; cyc();
    eng(2'd2, 16'h0, 16'h0, 1, 0); ioWrEn = 1; ioOffset = 4'hE; ioWrData = 0; cyc();
    eng(2'd1, 16'h5, 16'h6, 1, 1); ioWrEn = 1; ioOffset = 4'h9; ioWrData = 8'h05; cyc();
    eng(2'd3, 16'h9, 16'h9, 1, 0); ioWrEn = 1; ioOffset = 4'hA; ioWrData = 8'h03; cyc();
    eng(2'd1, 16'h5, 16'h6, 0, 0); ioWrEn = 1; ioOffset = 4'h2; ioWrData = 8'h3A; cyc();
    hr(4'h8); hr(4'hF);

    curReq = "R13";
    repeat (3) cyc();

    curReq = "R4";
    hw(4'h8, 8'hFF); hw(4'h6, 8'h12); hw(4'hD, 8'h00); hr(4'h6); hr(4'hD);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule